// File: doc/BRIEF.md
# Page-Buffered Write Sequencer with One-Time Lower-Half Lock

This block sits behind a two-wire serial memory protocol engine. The engine reports a start address, then each received data byte, then a stop event. The sequencer collects the bytes in a page buffer of `PAGE_BYTES` entries. The stop event commits the buffer to a register-array model of the memory. The commit runs through a self-timed busy interval of `BUSY_CYC` clock cycles. Nothing reaches the array before the stop, and the new bytes appear in the array when busy falls.

Successive bytes use consecutive slots in the page. Only the low address bits advance, so a write longer than a page wraps to the start of the same page and overwrites earlier bytes. The block also holds a one-time lock flag that is set by a pulse from the engine. Once the lock is set, the array below `PROT_LIMIT` can never be written again, and only a reset clears it. While busy is high the sequencer ignores every command, which lets the engine withhold its acknowledge. A separate combinational port reads the array. The pointer output gives the engine the base for its next current-address read.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, busy and locked are 0, cur_ptr is 0x00 and every array byte reads 0x00.
- R2: The k-th data byte after an address load at A goes to page-block A[7:4] at offset (A[3:0]+k) mod 16. A 17th byte therefore overwrites the first byte's location.
- R3: The array does not change while bytes are being received or while busy is high. The buffered bytes are readable in the first cycle after busy falls.
- R4: A stop pulse with at least one buffered byte raises busy on the next clock edge. Busy then stays high for exactly BUSY_CYC cycles.
- R5: While locked is 1, a committed byte whose address is below 0x80 is discarded. A write to 0x80 or above is still stored, and a write to a protected page still runs the busy interval.
- R6: A lock_pulse while not busy sets locked on the next edge. Locked stays 1 until reset, and further lock pulses change nothing.
- R7: A stop pulse with no buffered data bytes (address phase only) leaves busy low.
- R8: While busy is high, address, data, stop and lock pulses are ignored. cur_ptr, locked and the committed contents are unaffected, and no second busy interval follows.
- R9: cur_ptr equals the loaded address after an address pulse. After a data byte it equals the address that byte was stored at, and it keeps that value through the commit.
- R10: A data pulse outside an open address phase (none since the last stop) is dropped. It starts no write and does not move cur_ptr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_vld | input | 1 | One-cycle pulse: start address valid, opens an address phase |
| addr_in | input | 8 | Start byte address |
| byte_vld | input | 1 | One-cycle pulse: data byte received |
| byte_in | input | 8 | Data byte |
| stop_pulse | input | 1 | One-cycle pulse: bus stop, commits the buffered page |
| lock_pulse | input | 1 | One-cycle pulse: completed write to the lock register |
| busy | output | 1 | Self-timed write interval in progress |
| locked | output | 1 | Lower-half protection flag |
| cur_ptr | output | 8 | Address pointer (last loaded or last written address) |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |

## Verification
The embedded properties assume that the protocol engine raises at most one of addr_vld, byte_vld and stop_pulse in any cycle. They also assume that every pulse lasts exactly one cycle. The bench drives each command on a falling edge and removes it on the next falling edge, so every command is seen by exactly one rising edge and no two commands overlap. The pulses sent during a busy interval follow the same rule and deliberately fall inside the interval, so the ignore behaviour is observed at the ports rather than assumed.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int BLK_W     = ADDR_W - PG_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic                         addr_vld,
    input  logic [ADDR_W-1:0]            addr_in,
    input  logic                         byte_vld,
    input  byte_t                        byte_in,
    input  logic                         stop,
    input  logic                         clr,
    output logic [BLK_W-1:0]             blk_o,
    output logic [PAGE_BYTES-1:0]        mask_o,
    output logic [PAGE_BYTES-1:0][7:0]   data_o,
    output logic [ADDR_W-1:0]            ptr_o
);

    typedef struct packed {
        logic                       open;
        logic [BLK_W-1:0]           blk;
        logic [PG_W-1:0]            nxt;
        logic [PAGE_BYTES-1:0]      mask;
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [ADDR_W-1:0]          ptr;
    } buf_st_t;

    buf_st_t buf_d, buf_q;
    logic    take_byte;

    assign take_byte = accept && !addr_vld && byte_vld && buf_q.open;

    always_comb begin
        buf_d = buf_q;
        if (accept) begin
            if (addr_vld) begin
                buf_d.open = 1'b1;
                buf_d.blk  = addr_in[ADDR_W-1:PG_W];
                buf_d.nxt  = addr_in[PG_W-1:0];
                buf_d.ptr  = addr_in;
                buf_d.mask = '0;
            end else if (byte_vld && buf_q.open) begin
                buf_d.data[buf_q.nxt] = byte_in;
                buf_d.mask[buf_q.nxt] = 1'b1;
                buf_d.ptr             = {buf_q.blk, buf_q.nxt};
                buf_d.nxt             = buf_q.nxt + PG_W'(1);
            end else if (stop) begin
                buf_d.open = 1'b0;
            end
        end
        if (clr) begin
            buf_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign blk_o  = buf_q.blk;
    assign mask_o = buf_q.mask;
    assign data_o = buf_q.data;
    assign ptr_o  = buf_q.ptr;

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        take_byte |=> (buf_q.blk == $past(buf_q.blk))); // R2
    AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && !clr) |=> buf_q.mask[$past(buf_q.nxt)]); // R2
    AST_CLOSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !addr_vld && byte_vld && !buf_q.open) |=> $stable(buf_q.ptr)); // R10

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int BUSY_CYC = 40,
    localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic done_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t tmr_d, tmr_q;
    logic    done;

    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (start && !tmr_q.busy) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(BUSY_CYC - 1);
        end else if (done) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign done_o = done;

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != '0) |=> tmr_q.busy); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tmr_q.busy); // R8

endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int BLK_W     = ADDR_W - PG_W,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [BLK_W-1:0]           blk,
    input  logic [PAGE_BYTES-1:0]      mask,
    input  logic [PAGE_BYTES-1:0][7:0] data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output byte_t                      rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
    } arr_st_t;

    arr_st_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (we) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) begin
                    arr_d.mem[{blk, PG_W'(i)}] = data[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign rd_data = arr_q.mem[rd_addr];

    AST_ARRAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(arr_q.mem)); // R3

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int BUSY_CYC   = 40,
    parameter int PROT_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              stop_pulse,
    input  logic              lock_pulse,
    output logic              busy,
    output logic              locked,
    output logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int BLK_W = ADDR_W - PG_W;

    typedef struct packed {
        logic lock;
    } top_st_t;

    top_st_t top_d, top_q;

    logic                       accept;
    logic                       start;
    logic                       done;
    logic                       busy_w;
    logic [BLK_W-1:0]           blk;
    logic [PAGE_BYTES-1:0]      mask;
    logic [PAGE_BYTES-1:0]      wr_mask;
    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [ADDR_W-1:0]          ptr;
    byte_t                      rd_byte;

    assign accept = !busy_w;
    assign start  = accept && stop_pulse && !addr_vld && !byte_vld && (|mask);

    always_comb begin
        top_d = top_q;
        if (accept && lock_pulse) begin
            top_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_guard
            logic prot;
            assign prot       = top_q.lock && (int'({blk, PG_W'(g)}) < PROT_LIMIT);
            assign wr_mask[g] = mask[g] && !prot;
        end
    endgenerate

    pgwr_pagebuf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_vld (addr_vld),
        .addr_in  (addr_in),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .stop     (stop_pulse),
        .clr      (done),
        .blk_o    (blk),
        .mask_o   (mask),
        .data_o   (pg_data),
        .ptr_o    (ptr)
    );

    pgwr_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy_o (busy_w),
        .done_o (done)
    );

    pgwr_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (done),
        .blk     (blk),
        .mask    (wr_mask),
        .data    (pg_data),
        .rd_addr (rd_addr),
        .rd_data (rd_byte)
    );

    assign busy    = busy_w;
    assign locked  = top_q.lock;
    assign cur_ptr = ptr;
    assign rd_data = rd_byte;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.lock |=> top_q.lock); // R6
    AST_LOWER_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.lock && done && (int'(blk) * PAGE_BYTES + PAGE_BYTES <= PROT_LIMIT)) |-> (wr_mask == '0)); // R5
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && stop_pulse && !addr_vld && !byte_vld && mask == '0) |=> !busy_w); // R7
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |=> $stable(ptr)); // R8
    AST_STOP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_w); // R4

endmodule

// File: tb/pgwr_seq_tb_top.sv
`timescale 1ns/1ps
module pgwr_seq_tb_top;

    localparam int BUSY = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_vld = 1'b0;
    logic [7:0] addr_in = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       stop_pulse = 1'b0;
    logic       lock_pulse = 1'b0;
    logic       busy;
    logic       locked;
    logic [7:0] cur_ptr;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] exp_mem [256];
    bit   exp_lock = 1'b0;

    // Fields: start address, byte count, data seed (byte k = seed + 7k)
    localparam logic [23:0] VEC [5] = '{24'h800111, 24'h931040, 24'hA51403,
                                        24'h1003C0, 24'hF8115A};

    always #2.5 clk = ~clk;

    pgwr_seq #(.BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_in(byte_in), .stop_pulse(stop_pulse),
        .lock_pulse(lock_pulse), .busy(busy), .locked(locked), .cur_ptr(cur_ptr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_addr(input logic [7:0] a);
        @(negedge clk); addr_vld = 1'b1; addr_in = a;
        @(negedge clk); addr_vld = 1'b0;
    endtask

    task automatic t_byte(input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_in = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic t_stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask

    task automatic t_lock();
        @(negedge clk); lock_pulse = 1'b1;
        @(negedge clk); lock_pulse = 1'b0;
    endtask

    task automatic t_wait(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic chk_mem(input logic [7:0] a, input string tag);
        rd_addr = a;
        #1;
        chk(rd_data === exp_mem[a], tag, rd_data, exp_mem[a]);
    endtask

    function automatic void model_write(input logic [7:0] a, input int cnt, input logic [7:0] seed);
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] loc;
            loc = {a[7:4], 4'(a[3:0] + 4'(k))};
            if (!(exp_lock && loc < 8'h80)) exp_mem[loc] = 8'(seed + 8'(7 * k));
        end
    endfunction

    task automatic page_write(input logic [7:0] a, input int cnt, input logic [7:0] seed);
        t_addr(a);
        for (int k = 0; k < cnt; k++) t_byte(8'(seed + 8'(7 * k)));
    endtask

    initial begin
        int n;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(locked === 1'b0, "R1 locked", locked, 0);
        chk(cur_ptr === 8'h00, "R1 cur_ptr", cur_ptr, 0);
        chk_mem(8'h00, "R1 mem");
        chk_mem(8'hFF, "R1 mem");

        // Table-driven page writes
        for (int v = 0; v < 5; v++) begin
            logic [7:0] a;
            int         cnt;
            logic [7:0] seed;
            logic [7:0] lastp;
            a = VEC[v][23:16]; cnt = int'(VEC[v][15:8]); seed = VEC[v][7:0];
            page_write(a, cnt, seed);
            chk_mem(a, "R3 before stop");
            t_stop();
            chk(busy === 1'b1, "R4 busy rise", busy, 1);
            chk_mem(a, "R3 during busy");
            t_wait(n);
            chk(n == BUSY, "R4 busy length", n, BUSY);
            model_write(a, cnt, seed);
            lastp = {a[7:4], 4'(a[3:0] + 4'(cnt - 1))};
            chk(cur_ptr === lastp, "R9 ptr after commit", cur_ptr, lastp);
            for (int k = 0; k < 16; k++) chk_mem({a[7:4], 4'(k)}, "R2 page content");
        end

        // R7 address-only stop
        t_addr(8'h40);
        chk(cur_ptr === 8'h40, "R9 ptr after load", cur_ptr, 8'h40);
        t_stop();
        chk(busy === 1'b0, "R7 no busy", busy, 0);
        repeat (2) @(negedge clk);
        chk(busy === 1'b0, "R7 still idle", busy, 0);

        // R10 data outside an address phase
        t_byte(8'hEE);
        chk(cur_ptr === 8'h40, "R10 ptr unmoved", cur_ptr, 8'h40);
        t_stop();
        chk(busy === 1'b0, "R10 no write", busy, 0);
        chk_mem(8'h40, "R10 mem");

        // R8 commands during busy are ignored
        page_write(8'hB0, 1, 8'h21);
        t_stop();
        chk(busy === 1'b1, "R8 busy", busy, 1);
        t_lock();
        t_addr(8'h05);
        t_byte(8'h99);
        t_stop();
        chk(locked === 1'b0, "R8 lock ignored", locked, 0);
        chk(cur_ptr === 8'hB0, "R8 ptr held", cur_ptr, 8'hB0);
        t_wait(n);
        model_write(8'hB0, 1, 8'h21);
        @(negedge clk);
        chk(busy === 1'b0, "R8 no second cycle", busy, 0);
        chk_mem(8'hB0, "R8 committed");
        chk_mem(8'h05, "R8 stray byte");
        chk_mem(8'hB1, "R8 stray byte");

        // R6 lock set and sticky
        t_lock();
        exp_lock = 1'b1;
        chk(locked === 1'b1, "R6 lock set", locked, 1);

        // R5 protected page discarded, busy still runs
        page_write(8'h30, 3, 8'h77);
        t_stop();
        chk(busy === 1'b1, "R5 busy on protected", busy, 1);
        t_wait(n);
        chk(n == BUSY, "R5 busy length", n, BUSY);
        model_write(8'h30, 3, 8'h77);
        chk_mem(8'h30, "R5 protected");
        chk_mem(8'h32, "R5 protected");

        page_write(8'h7F, 1, 8'h5E);
        t_stop(); t_wait(n);
        model_write(8'h7F, 1, 8'h5E);
        chk_mem(8'h7F, "R5 boundary low");

        page_write(8'h80, 1, 8'hA9);
        t_stop(); t_wait(n);
        model_write(8'h80, 1, 8'hA9);
        chk_mem(8'h80, "R5 boundary high");

        page_write(8'hC4, 2, 8'h3C);
        t_stop(); t_wait(n);
        model_write(8'hC4, 2, 8'h3C);
        chk_mem(8'hC4, "R5 upper write");
        chk_mem(8'hC5, "R5 upper write");

        t_lock();
        chk(locked === 1'b1, "R6 lock still set", locked, 1);
        chk(busy === 1'b0, "R6 lock no busy", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule